// File: doc/BRIEF.md
# Cache-Line Pointer Candidate Scanner

This block looks through a freshly filled cache line for words that are probably pointers, so that a content-directed prefetcher can follow them. It takes the whole line together with the virtual effective address of the request that caused the fill. Every word position allowed by the configured byte step is judged at the same time. A word is kept when its high-order bits equal those of the triggering address. Two extra tests keep out data values. A word in the all-zero or all-one high region must show activity in the filter bits just below the compared bits. A word with any nonzero bit among its lowest alignment bits is discarded.

The compare width N, filter width M, alignment width A and scan step are runtime inputs, and they are captured with the line. A typical setting is N=8, M=4, A=1 with a 2-byte step. Candidates are delivered one per handshake, lowest byte offset first. The block refuses a new line until the last candidate of the current line has been taken. Address translation, cache storage and request issue belong to neighbouring blocks.

Top module: `ptr_scan`

## Requirements
- R1: A line, its triggering address and its configuration are taken on a rising edge where `line_valid` and `line_ready` are both high. A line held at the input while `line_ready` is low is not taken until every candidate of the current line has been delivered.
- R2: A word is a candidate only if its upper N bits equal the upper N bits of the triggering address.
- R3: When the word's upper N bits are all zero, the word is a candidate only if the next M bits below them contain at least one 1.
- R4: When the word's upper N bits are all one, the word is a candidate only if the next M bits below them contain at least one 0.
- R5: With M=0, no word whose upper N bits are all zero or all one is ever a candidate.
- R6: A word with any 1 among its lowest A bits is never a candidate.
- R7: The scan step is 2^`cfg_step_lg` bytes. Only byte offsets that are multiples of the step and leave the whole 4-byte word inside the 64-byte line (offsets 0 to 60) are evaluated.
- R8: `cand_addr` is the word assembled little-endian from bytes offset to offset+3 of the line, where byte k is `line_data[8k+7:8k]`. `cand_offset` is that byte offset.
- R9: Candidates leave in strictly ascending offset order, one per cycle with `cand_valid` and `cand_ready` high. The first one is valid in the cycle after the line is taken. Address and offset hold steady while `cand_ready` is low.
- R10: After reset, `line_ready` is 1 and `cand_valid` is 0. `line_ready` is low exactly while candidates of the current line remain. A line with no candidates leaves `line_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | 1 | A filled line is presented |
| line_ready | output | 1 | Scanner is idle and takes a line |
| line_data | input | 512 | Line contents, byte k at bits 8k+7:8k |
| trig_addr | input | 32 | Virtual effective address of the triggering request |
| cfg_cmp_bits | input | 7 | Number of compared high bits N |
| cfg_filt_bits | input | 7 | Number of filter bits M |
| cfg_align_bits | input | 7 | Number of alignment bits A |
| cfg_step_lg | input | 2 | Log2 of the scan step in bytes |
| cand_valid | output | 1 | A candidate pointer is offered |
| cand_ready | input | 1 | Consumer takes the candidate |
| cand_addr | output | 32 | Candidate pointer value |
| cand_offset | output | 6 | Byte offset of the candidate in the line |

## Verification
The assertions check on every cycle that each offered candidate shares the captured high bits with the triggering address and has clear alignment bits. They also check that its offset lies on the captured step inside the line, that offsets rise after each transfer, that a stalled candidate holds, and that the captured line is not replaced while busy. Only the bench's scenarios can show the completeness side: which words in the all-zero and all-one regions the filter keeps or drops, and that M=0 empties those regions. The same holds for the little-endian assembly of straddling words, and for a line waiting at the input being taken only after the previous line drains.

// File: rtl/ptr_scan_pkg.sv
package ptr_scan_pkg;
   localparam int unsigned CFG_W     = 7;
   localparam int unsigned STEP_LG_W = 2;

   typedef struct packed {
      logic [CFG_W-1:0]     cmp_bits;
      logic [CFG_W-1:0]     filt_bits;
      logic [CFG_W-1:0]     align_bits;
      logic [STEP_LG_W-1:0] step_lg;
   } scan_cfg_t;
endpackage

// File: rtl/ptr_scan_masks.sv
module ptr_scan_masks
   import ptr_scan_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  scan_cfg_t          cfg,
   output logic [WORD_W-1:0]  hi_mask,
   output logic [WORD_W-1:0]  filt_mask,
   output logic [WORD_W-1:0]  align_mask
);
   localparam logic [WORD_W-1:0] ONES = '1;

   if (WORD_W >= (1 << CFG_W)) begin : g_bad_width
      $error("ptr_scan_masks: WORD_W exceeds configuration field range");
   end

   logic [WORD_W-1:0] below;

   always_comb begin
      below      = ONES >> cfg.cmp_bits;
      hi_mask    = ~below;
      filt_mask  = below & ~(below >> cfg.filt_bits);
      align_mask = ~(ONES << cfg.align_bits);
   end
endmodule

// File: rtl/ptr_scan_lane.sv
module ptr_scan_lane #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              en,
   input  logic [WORD_W-1:0] word,
   input  logic [WORD_W-1:0] trig,
   input  logic [WORD_W-1:0] hi_mask,
   input  logic [WORD_W-1:0] filt_mask,
   input  logic [WORD_W-1:0] align_mask,
   output logic              hit
);
   logic [WORD_W-1:0] top_bits;
   logic [WORD_W-1:0] filt_sel;
   logic              same_region;
   logic              low_region;
   logic              high_region;
   logic              filt_ok;

   always_comb begin
      top_bits    = word & hi_mask;
      same_region = (top_bits == (trig & hi_mask));
      low_region  = (top_bits == '0);
      high_region = (top_bits == hi_mask);
      filt_sel    = word & filt_mask;
      if (low_region)       filt_ok = |filt_sel;
      else if (high_region) filt_ok = (filt_sel != filt_mask);
      else                  filt_ok = 1'b1;
      hit = en & same_region & filt_ok & ((word & align_mask) == '0);
   end
endmodule

// File: rtl/ptr_scan_pick.sv
module ptr_scan_pick #(
   parameter int unsigned N  = 61,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("ptr_scan_pick: N must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/ptr_scan.sv
module ptr_scan
   import ptr_scan_pkg::*;
#(
   parameter  int unsigned LINE_BYTES = 64,
   parameter  int unsigned WORD_BYTES = 4,
   localparam int unsigned WORD_W     = WORD_BYTES * 8,
   localparam int unsigned LINE_W     = LINE_BYTES * 8,
   localparam int unsigned OFF_W      = $clog2(LINE_BYTES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_valid,
   output logic                 line_ready,
   input  logic [LINE_W-1:0]    line_data,
   input  logic [WORD_W-1:0]    trig_addr,
   input  logic [CFG_W-1:0]     cfg_cmp_bits,
   input  logic [CFG_W-1:0]     cfg_filt_bits,
   input  logic [CFG_W-1:0]     cfg_align_bits,
   input  logic [STEP_LG_W-1:0] cfg_step_lg,
   output logic                 cand_valid,
   input  logic                 cand_ready,
   output logic [WORD_W-1:0]    cand_addr,
   output logic [OFF_W-1:0]     cand_offset
);
   localparam int unsigned NPOS     = LINE_BYTES - WORD_BYTES + 1;
   localparam int unsigned LAST_OFF = NPOS - 1;
   localparam int unsigned IW       = $clog2(NPOS);

   if (WORD_BYTES < 1 || WORD_BYTES > 8) begin : g_bad_word
      $error("ptr_scan: WORD_BYTES must be 1 to 8");
   end
   if (LINE_BYTES < 2 * WORD_BYTES) begin : g_bad_line
      $error("ptr_scan: line must hold at least two words");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_pow2
      $error("ptr_scan: LINE_BYTES must be a power of two");
   end

   scan_cfg_t         cfg_in;
   logic [WORD_W-1:0] hi_in, filt_in, al_in;
   logic [OFF_W-1:0]  step_msk;
   logic [NPOS-1:0]   hit_vec;

   always_comb begin
      cfg_in.cmp_bits   = cfg_cmp_bits;
      cfg_in.filt_bits  = cfg_filt_bits;
      cfg_in.align_bits = cfg_align_bits;
      cfg_in.step_lg    = cfg_step_lg;
      step_msk          = ~({OFF_W{1'b1}} << cfg_step_lg);
   end

   ptr_scan_masks #(.WORD_W(WORD_W)) u_masks (
      .cfg        (cfg_in),
      .hi_mask    (hi_in),
      .filt_mask  (filt_in),
      .align_mask (al_in)
   );

   for (genvar p = 0; p < NPOS; p++) begin : g_lane
      localparam logic [OFF_W-1:0] OFF = OFF_W'(p);
      logic on_step;
      assign on_step = ((OFF & step_msk) == '0);
      ptr_scan_lane #(.WORD_W(WORD_W)) u_lane (
         .en         (on_step),
         .word       (line_data[p*8 +: WORD_W]),
         .trig       (trig_addr),
         .hi_mask    (hi_in),
         .filt_mask  (filt_in),
         .align_mask (al_in),
         .hit        (hit_vec[p])
      );
   end

   logic [NPOS-1:0]   pend;
   logic [LINE_W-1:0] line_q;
   logic [WORD_W-1:0] trig_q, hi_q, al_q;
   logic [OFF_W-1:0]  smsk_q;
   logic              any_pend;
   logic [IW-1:0]     pick_idx;
   logic              accept, pop;

   ptr_scan_pick #(.N(NPOS), .IW(IW)) u_pick (
      .req (pend),
      .any (any_pend),
      .idx (pick_idx)
   );

   assign accept      = line_valid & line_ready;
   assign pop         = cand_valid & cand_ready;
   assign line_ready  = ~any_pend;
   assign cand_valid  = any_pend;
   assign cand_offset = OFF_W'(pick_idx);
   assign cand_addr   = WORD_W'(line_q >> {pick_idx, 3'b000});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= '0;
         line_q <= '0;
         trig_q <= '0;
         hi_q   <= '0;
         al_q   <= '0;
         smsk_q <= '0;
      end else if (accept) begin
         pend   <= hit_vec;
         line_q <= line_data;
         trig_q <= trig_addr;
         hi_q   <= hi_in;
         al_q   <= al_in;
         smsk_q <= step_msk;
      end else if (pop) begin
         pend[pick_idx] <= 1'b0;
      end
   end

   assert_hold_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !line_ready |=> $stable(trig_q) && $stable(line_q));

   assert_high_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> (((cand_addr ^ trig_q) & hi_q) == '0));

   assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> ((cand_addr & al_q) == '0));

   assert_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> (((cand_offset & smsk_q) == '0) && (cand_offset <= OFF_W'(LAST_OFF))));

   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && !cand_ready |=> cand_valid && $stable(cand_addr) && $stable(cand_offset));

   assert_ascending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && cand_ready |=> !cand_valid || (cand_offset > $past(cand_offset)));
endmodule

// File: tb/ptr_scan_tb_top.sv
module ptr_scan_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         line_valid = 1'b0;
   logic         line_ready;
   logic [511:0] line_data = '0;
   logic [31:0]  trig_addr = '0;
   logic [6:0]   cfg_cmp_bits = 7'd8;
   logic [6:0]   cfg_filt_bits = 7'd4;
   logic [6:0]   cfg_align_bits = 7'd1;
   logic [1:0]   cfg_step_lg = 2'd1;
   logic         cand_valid;
   logic         cand_ready = 1'b1;
   logic [31:0]  cand_addr;
   logic [5:0]   cand_offset;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit stall_en = 1'b0;
   bit done = 1'b0;

   int          exp_off[$];
   logic [31:0] exp_val[$];
   int          got_off[$];
   logic [31:0] got_val[$];

   always #5 clk = ~clk;

   ptr_scan dut_i (
      .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_ready(line_ready),
      .line_data(line_data), .trig_addr(trig_addr), .cfg_cmp_bits(cfg_cmp_bits),
      .cfg_filt_bits(cfg_filt_bits), .cfg_align_bits(cfg_align_bits),
      .cfg_step_lg(cfg_step_lg), .cand_valid(cand_valid), .cand_ready(cand_ready),
      .cand_addr(cand_addr), .cand_offset(cand_offset)
   );

   task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Behavioural model of the pointer rules, applied word by word.
   task automatic model_load(input logic [511:0] l, input logic [31:0] t,
                             input int n, input int m, input int a, input int s);
      for (int o = 0; o + 4 <= 64; o++) begin
         logic [31:0] w;
         bit hiok, allz, allo, fone, fzero, ok;
         if ((o % (1 << s)) != 0) continue;
         w = l[o*8 +: 32];
         hiok = 1; allz = 1; allo = 1; fone = 0; fzero = 0;
         for (int b = 31; b >= 32 - n; b--) begin
            if (w[b] != t[b]) hiok = 0;
            if (w[b]) allz = 0; else allo = 0;
         end
         for (int b = 31 - n; b >= 32 - n - m && b >= 0; b--) begin
            if (w[b]) fone = 1; else fzero = 1;
         end
         ok = hiok;
         if (allz) ok = ok & fone;
         else if (allo) ok = ok & fzero;
         for (int b = 0; b < a; b++) if (w[b]) ok = 0;
         if (ok) begin
            exp_off.push_back(o);
            exp_val.push_back(w);
         end
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cyc++;
         chk("R10 line_ready", line_ready == (exp_off.size() == 0), 32'(line_ready), 32'(exp_off.size() == 0));
         chk("R9 cand_valid", cand_valid == (exp_off.size() != 0), 32'(cand_valid), 32'(exp_off.size() != 0));
         if (exp_off.size() != 0 && cand_valid) begin
            chk("R8 cand_addr", cand_addr == exp_val[0], cand_addr, exp_val[0]);
            chk("R9 cand_offset", 32'(cand_offset) == 32'(exp_off[0]), 32'(cand_offset), 32'(exp_off[0]));
         end
         if (line_valid && exp_off.size() == 0) begin
            model_load(line_data, trig_addr, int'(cfg_cmp_bits), int'(cfg_filt_bits),
                       int'(cfg_align_bits), int'(cfg_step_lg));
         end else if (cand_valid && cand_ready && exp_off.size() != 0) begin
            got_off.push_back(int'(cand_offset));
            got_val.push_back(cand_addr);
            void'(exp_off.pop_front());
            void'(exp_val.pop_front());
         end
         if (cyc > 20000) begin
            chk("watchdog", 1'b0, 32'(cyc), 32'd20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         #2;
         cand_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
      end
   end

   function automatic logic [511:0] plant(input logic [511:0] l, input int off, input logic [31:0] v);
      logic [511:0] r;
      r = l;
      r[off*8 +: 32] = v;
      return r;
   endfunction

   task automatic send(input logic [511:0] l, input logic [31:0] t,
                       input int n, input int m, input int a, input int s);
      @(posedge clk); #2;
      line_data = l; trig_addr = t;
      cfg_cmp_bits = 7'(n); cfg_filt_bits = 7'(m); cfg_align_bits = 7'(a); cfg_step_lg = 2'(s);
      line_valid = 1'b1;
      @(negedge clk);
      while (!line_ready) @(negedge clk);
      @(posedge clk); #2;
      line_valid = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (!line_ready) @(negedge clk);
      #1;
   endtask

   task automatic clear_got();
      got_off.delete();
      got_val.delete();
   endtask

   logic [511:0] ln_a, ln_z, ln_o, ln_s, ln_b, ln_m;

   initial begin
      ln_a = '0;
      ln_a = plant(ln_a, 4, 32'h1200_0010);
      ln_a = plant(ln_a, 12, 32'h1200_0011);
      ln_a = plant(ln_a, 20, 32'h1300_0010);
      ln_a = plant(ln_a, 28, 32'h1200_0002);
      ln_z = plant(plant('0, 8, 32'h0010_0000), 20, 32'h0008_0000);
      ln_o = plant(plant('0, 16, 32'hFF70_0000), 24, 32'hFFF0_0000);
      ln_s = plant(plant('0, 6, 32'h1200_0010), 32, 32'h1200_0010);
      ln_b = plant('0, 59, 32'h1200_0020);
      ln_m = '0;
      ln_m = plant(ln_m, 0, 32'h1200_0100);
      ln_m = plant(ln_m, 8, 32'h1200_0100);
      ln_m = plant(ln_m, 40, 32'h1200_0100);
      ln_m = plant(ln_m, 60, 32'h1200_0100);

      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R10 reset ready", line_ready === 1'b1, 32'(line_ready), 32'd1);
      chk("R10 reset valid", cand_valid === 1'b0, 32'(cand_valid), 32'd0);

      // R2 / R6 / R8: A=2 keeps only offset 4
      clear_got();
      send(ln_a, 32'h1234_5678, 8, 4, 2, 1); drain();
      chk("R2 count", got_off.size() == 1, 32'(got_off.size()), 32'd1);
      if (got_off.size() > 0) begin
         chk("R8 value", got_val[0] == 32'h1200_0010, got_val[0], 32'h1200_0010);
         chk("R2 offset", got_off[0] == 4, 32'(got_off[0]), 32'd4);
      end
      // R6: A=1 lets offset 28 through
      clear_got();
      send(ln_a, 32'h1234_5678, 8, 4, 1, 1); drain();
      chk("R6 count", got_off.size() == 2, 32'(got_off.size()), 32'd2);
      if (got_off.size() > 1) chk("R6 offset", got_off[1] == 28, 32'(got_off[1]), 32'd28);

      // R3: zero region
      clear_got();
      send(ln_z, 32'h0040_0000, 8, 4, 1, 1); drain();
      chk("R3 count", got_off.size() == 1, 32'(got_off.size()), 32'd1);
      if (got_off.size() > 0) chk("R3 offset", got_off[0] == 8, 32'(got_off[0]), 32'd8);

      // R4: ones region
      clear_got();
      send(ln_o, 32'hFF80_0000, 8, 4, 1, 1); drain();
      chk("R4 count", got_off.size() == 1, 32'(got_off.size()), 32'd1);
      if (got_off.size() > 0) chk("R4 value", got_val[0] == 32'hFF70_0000, got_val[0], 32'hFF70_0000);

      // R5: M=0 empties both regions
      clear_got();
      send(ln_z, 32'h0040_0000, 8, 0, 1, 1); drain();
      chk("R5 zero region", got_off.size() == 0, 32'(got_off.size()), 32'd0);
      chk("R10 no-candidate ready", line_ready === 1'b1, 32'(line_ready), 32'd1);
      clear_got();
      send(ln_o, 32'hFF80_0000, 8, 0, 1, 1); drain();
      chk("R5 ones region", got_off.size() == 0, 32'(got_off.size()), 32'd0);

      // R7: 4-byte step skips offset 6
      clear_got();
      send(ln_s, 32'h1234_5678, 8, 4, 1, 2); drain();
      chk("R7 count", got_off.size() == 1, 32'(got_off.size()), 32'd1);
      if (got_off.size() > 0) chk("R7 offset", got_off[0] == 32, 32'(got_off[0]), 32'd32);
      // R7: byte step reaches the last odd offset
      clear_got();
      send(ln_b, 32'h1234_5678, 8, 4, 1, 0); drain();
      chk("R7 byte step", got_off.size() == 1, 32'(got_off.size()), 32'd1);
      if (got_off.size() > 0) chk("R7 last offset", got_off[0] == 59, 32'(got_off[0]), 32'd59);

      // R9 / R1: stalled drain, second line waits at the input
      clear_got();
      stall_en = 1'b1;
      send(ln_m, 32'h1234_5678, 8, 4, 1, 2);
      send(ln_a, 32'h1234_5678, 8, 4, 2, 1);
      drain();
      stall_en = 1'b0;
      chk("R1 total", got_off.size() == 5, 32'(got_off.size()), 32'd5);
      if (got_off.size() == 5) begin
         chk("R9 order 0", got_off[0] == 0, 32'(got_off[0]), 32'd0);
         chk("R9 order 2", got_off[2] == 40, 32'(got_off[2]), 32'd40);
         chk("R9 order 3", got_off[3] == 60, 32'(got_off[3]), 32'd60);
         chk("R1 second line", got_off[4] == 4, 32'(got_off[4]), 32'd4);
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule